// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block turns bytes handed over by a host into asynchronous serial frames on one output line. A byte enters through a valid/ready write port and waits in storage. A single entry acts as a holding register in the plain mode, and a 64-entry queue takes that role when the queue mode bit is set. A frame shifter then sends the byte. Each frame has a low start bit, then 5 to 8 data bits with bit 0 first, then an optional even or odd parity bit, then one or two high stop bits. The timing of one bit is counted from an oversampling strobe input, `os_tick`. A bit lasts 16 strobes, or 8 strobes when `cfg_os8` is set.

The block reports two status levels. `thr_empty` means that storage holds no byte. `tsr_empty` means that the shifter has finished its last stop bit. A transmit-empty interrupt follows `thr_empty` while its enable bit is set.

Write port rules:
- A byte transfers only on a clock edge where `wr_valid` and `wr_ready` are both high.
- `wr_ready` is high while storage has room: fewer than DEPTH bytes in queue mode, or no byte in plain mode.
- A `wr_valid` presented while `wr_ready` is low is dropped. The host may keep it held and retry.

All `cfg_*` inputs must be changed only while both status flags are high.

Top module: `utx_top`

## Requirements
- R1: During reset and directly after it, `txd`=1, `thr_empty`=1, `tsr_empty`=1 and `wr_ready`=1.
- R2: Storage holds up to DEPTH (64) bytes when `cfg_fifo_en`=1 and one byte when it is 0. `wr_ready` is low exactly when storage is full, and a valid beat offered while it is low is not stored.
- R3: A frame is sent in this order: a start bit of 0; then 5+`cfg_len` data bits (`cfg_len` 0..3), bit 0 first; then, if `cfg_par_en`=1, a parity bit; then one stop bit of 1, or two when `cfg_stop2`=1. The parity bit makes the count of ones over the data bits and the parity bit even when `cfg_par_odd`=0, and odd when `cfg_par_odd`=1.
- R4: Each bit of a frame lasts 16 `os_tick` pulses, or 8 when `cfg_os8`=1. Counting starts at the edge that loads the shifter.
- R5: `thr_empty` falls on the edge after an accepted write. It rises on the edge where the last stored byte moves into the shifter.
- R6: `tsr_empty` goes low at the edge that loads a byte. It goes high at the edge that ends the final stop bit, unless another byte is loaded at that same edge.
- R7: `irq` equals `thr_empty` while `cfg_ie_thre`=1 and is 0 while `cfg_ie_thre`=0. A write therefore clears a pending interrupt.
- R8: When a byte is waiting at the end of a frame's last stop bit, the next start bit begins at that same edge, with no idle bit time between the frames.
- R9: `txd` is 1 whenever `tsr_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling strobe, one cycle wide |
| cfg_fifo_en | input | 1 | 1 = 64-entry queue, 0 = single holding entry |
| cfg_os8 | input | 1 | 1 = 8 strobes per bit, 0 = 16 |
| cfg_len | input | 2 | Data length minus 5 |
| cfg_par_en | input | 1 | Insert a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| cfg_ie_thre | input | 1 | Transmit-empty interrupt enable |
| wr_valid | input | 1 | Host offers a byte |
| wr_ready | output | 1 | Storage can accept a byte |
| wr_data | input | 8 | Byte offered |
| txd | output | 1 | Serial line, idles high |
| thr_empty | output | 1 | Storage holds no byte |
| tsr_empty | output | 1 | Shifter idle |
| irq | output | 1 | Transmit-empty interrupt |

## Verification
The bench goes after the edge where a frame's last stop bit ends while another byte waits. A design that inserted an idle bit there, or dropped or repeated the waiting byte, would put `txd` out of step with the reference model (R8).

It fills the queue past 64 with one-cycle write pulses. A design that overwrote storage or kept `wr_ready` high when full would send extra or wrong bytes (R2).

It runs 5-bit frames with even parity and two stop bits at 8x with sparse strobes, and 7-bit frames with odd parity. Wrong parity, a wrong data length or bits counted on plain clocks would show up there (R3, R4).

It toggles the interrupt enable while status changes. A level that ignored the enable or did not fall on a write would fail (R7).

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int OS_SLOW   = 16;
  localparam int OS_FAST   = 8;
  localparam int FRAME_MAX = 12;
  localparam int NB_W      = $clog2(FRAME_MAX + 1);

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
  } frame_cfg_t;

  function automatic logic [NB_W-1:0] frame_bits(input frame_cfg_t c);
    logic [NB_W-1:0] n;
    n = NB_W'(7) + NB_W'(c.len) + NB_W'(c.par_en) + NB_W'(c.stop2);
    return n;
  endfunction

  function automatic logic [FRAME_MAX-1:0] frame_pack(input frame_cfg_t c,
                                                      input logic [7:0] d);
    logic [FRAME_MAX-1:0] f;
    logic [7:0]           m;
    int                   nd;
    nd = 5 + int'(c.len);
    f  = '1;
    f[0] = 1'b0;
    m  = 8'hFF >> (8 - nd);
    for (int i = 0; i < 8; i++) begin
      if (i < nd) f[1 + i] = d[i];
    end
    if (c.par_en) f[1 + nd] = (^(d & m)) ^ c.par_odd;
    return f;
  endfunction
endpackage

// File: rtl/utx_store.sv
module utx_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              din,
  input  logic                       pop,
  output logic [DW-1:0]              dout,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

  assign dout = mem[rp];
endmodule

// File: rtl/utx_baud.sv
module utx_baud (
  input  logic clk,
  input  logic rst_n,
  input  logic os_tick,
  input  logic os8,
  input  logic restart,
  input  logic run,
  output logic bit_end
);
  import utx_pkg::*;
  localparam int TW = $clog2(OS_SLOW);

  logic [TW-1:0] cnt;
  logic [TW-1:0] last;

  assign last    = os8 ? TW'(OS_FAST - 1) : TW'(OS_SLOW - 1);
  assign bit_end = run && os_tick && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (run && os_tick) cnt <= (cnt == last) ? '0 : cnt + TW'(1);
  end
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [7:0]         data,
  input  utx_pkg::frame_cfg_t cfg,
  input  logic               bit_end,
  output logic               busy,
  output logic               frame_done,
  output logic               txd
);
  import utx_pkg::*;

  logic [FRAME_MAX-1:0] sh;
  logic [NB_W-1:0]      left;

  assign frame_done = busy && bit_end && (left == '0);
  assign txd        = sh[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sh   <= frame_pack(cfg, data);
      left <= frame_bits(cfg) - NB_W'(1);
      busy <= 1'b1;
    end else if (busy && bit_end) begin
      if (left == '0) begin
        busy <= 1'b0;
        sh   <= '1;
      end else begin
        sh   <= {1'b1, sh[FRAME_MAX-1:1]};
        left <= left - NB_W'(1);
      end
    end
  end
endmodule

// File: rtl/utx_top.sv
module utx_top #(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       cfg_fifo_en,
  input  logic       cfg_os8,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  input  logic       cfg_ie_thre,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       thr_empty,
  output logic       tsr_empty,
  output logic       irq
);
  import utx_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] fill;
  logic [CW-1:0] cap;
  logic [7:0]    head;
  logic          push, load, busy, frame_done, bit_end;
  frame_cfg_t    fcfg;

  assign fcfg      = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};
  assign cap       = cfg_fifo_en ? CW'(DEPTH) : CW'(1);
  assign wr_ready  = fill < cap;
  assign push      = wr_valid && wr_ready;
  assign load      = (!busy || frame_done) && (fill != '0);
  assign thr_empty = (fill == '0);
  assign tsr_empty = !busy;
  assign irq       = cfg_ie_thre && thr_empty;

  utx_store #(.DEPTH(DEPTH), .DW(8)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .din(wr_data),
    .pop(load), .dout(head), .fill(fill)
  );

  utx_baud u_baud (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .os8(cfg_os8),
    .restart(load), .run(busy), .bit_end(bit_end)
  );

  utx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .data(head), .cfg(fcfg),
    .bit_end(bit_end), .busy(busy), .frame_done(frame_done), .txd(txd)
  );
endmodule

// File: rtl/utx_checker.sv
module utx_checker #(
  parameter int DEPTH = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_ie_thre,
  input logic                       wr_valid,
  input logic                       wr_ready,
  input logic                       txd,
  input logic                       thr_empty,
  input logic                       tsr_empty,
  input logic                       irq,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  assert_idle_mark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tsr_empty |-> txd);

  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tsr_empty) |-> !txd);

  assert_stop_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tsr_empty) |-> $past(txd));

  assert_write_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !thr_empty);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ($clog2(DEPTH+1))'(DEPTH));

  assert_empty_accepts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    thr_empty |-> wr_ready);

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (thr_empty && cfg_ie_thre));
endmodule

bind utx_top utx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ie_thre(cfg_ie_thre), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .txd(txd), .thr_empty(thr_empty), .tsr_empty(tsr_empty),
  .irq(irq), .fill(fill)
);

// File: tb/utx_top_bench.sv
module utx_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic cfg_fifo_en = 1'b0, cfg_os8 = 1'b0, cfg_par_en = 1'b0;
  logic cfg_par_odd = 1'b0, cfg_stop2 = 1'b0, cfg_ie_thre = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wr_ready, txd, thr_empty, tsr_empty, irq;

  int n_chk = 0, n_fail = 0;
  int tick_div = 1;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  utx_top u_utx_top (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .cfg_fifo_en(cfg_fifo_en),
    .cfg_os8(cfg_os8), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2), .cfg_ie_thre(cfg_ie_thre),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .txd(txd),
    .thr_empty(thr_empty), .tsr_empty(tsr_empty), .irq(irq)
  );

  // behavioural reference
  byte unsigned q[$];
  bit bq[$];
  bit m_busy = 0;
  int tcnt = 0;

  always @(posedge clk) begin
    int cap, osn, nd;
    bit can_wr, had, p;
    byte unsigned b;
    if (!rst_n) begin
      q.delete(); bq.delete(); m_busy = 0; tcnt = 0;
    end else begin
      cap = cfg_fifo_en ? 64 : 1;
      osn = cfg_os8 ? 8 : 16;
      can_wr = q.size() < cap;
      had = q.size() > 0;
      if (m_busy && os_tick) begin
        if (tcnt == osn - 1) begin
          tcnt = 0;
          void'(bq.pop_front());
          if (bq.size() == 0) m_busy = 0;
        end else tcnt++;
      end
      if (!m_busy && had) begin
        b = q.pop_front();
        nd = 5 + cfg_len;
        bq.push_back(1'b0);
        p = cfg_par_odd;
        for (int i = 0; i < nd; i++) begin
          bq.push_back(b[i]);
          p ^= b[i];
        end
        if (cfg_par_en) bq.push_back(p);
        bq.push_back(1'b1);
        if (cfg_stop2) bq.push_back(1'b1);
        m_busy = 1; tcnt = 0;
      end
      if (wr_valid && can_wr) q.push_back(wr_data);
    end
  end

  task automatic cmp(input string req, input string nm, input logic act, input logic exp);
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, nm, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    logic e_txd, e_thr;
    cyc++;
    if (!done) begin
      e_thr = (q.size() == 0);
      e_txd = m_busy ? bq[0] : 1'b1;
      n_chk++;
      if (!rst_n) begin
        cmp("R1", "txd", txd, 1'b1);
        cmp("R1", "thr_empty", thr_empty, 1'b1);
        cmp("R1", "tsr_empty", tsr_empty, 1'b1);
        cmp("R1", "wr_ready", wr_ready, 1'b1);
      end else begin
        cmp(m_busy ? "R3/R4/R8" : "R9", "txd", txd, e_txd);
        cmp("R5", "thr_empty", thr_empty, e_thr);
        cmp("R6", "tsr_empty", tsr_empty, !m_busy);
        cmp("R7", "irq", irq, cfg_ie_thre && e_thr);
        cmp("R2", "wr_ready", wr_ready, q.size() < (cfg_fifo_en ? 64 : 1));
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk); #1;
      os_tick = (cyc % tick_div) == 0;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic offer(input byte unsigned b);
    wr_data = b; wr_valid = 1'b1;
    step();
    wr_valid = 1'b0;
  endtask

  task automatic send(input byte unsigned b);
    int guard = 0;
    while (!wr_ready && guard < 20000) begin step(); guard++; end
    offer(b);
  endtask

  task automatic drain();
    int guard = 0;
    while (!(thr_empty && tsr_empty) && guard < 60000) begin step(); guard++; end
    step(); step();
  endtask

  initial begin
    repeat (4) step();
    rst_n = 1'b1;
    step();
    // R1 after reset; R3 8N1 at 16x, single-entry mode, R5 R6 R8
    tick_div = 1;
    cfg_ie_thre = 1'b1;
    send(8'hA5); send(8'h3C); send(8'hFF); send(8'h00);
    for (int i = 0; i < 30; i++) offer(8'h55);   // R2: offered while full
    drain();
    // R3 R4: 5 bits, even parity, two stops, 8x, sparse strobes
    cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_stop2 = 1'b1;
    cfg_os8 = 1'b1; tick_div = 3; cfg_ie_thre = 1'b0;
    send(8'h13); send(8'h1F); send(8'h0E);
    drain();
    // R2 R8: queue mode, 7 bits odd parity, burst past capacity
    cfg_fifo_en = 1'b1; cfg_len = 2'd2; cfg_par_odd = 1'b1; cfg_stop2 = 1'b0;
    tick_div = 1;
    for (int i = 0; i < 72; i++) offer(byte'(i * 37 + 5));
    for (int i = 0; i < 200; i++) begin
      cfg_ie_thre = (i % 50) < 25;   // R7: enable toggles
      step();
    end
    cfg_ie_thre = 1'b1;
    drain();
    // R7 R8: 6 bits, no parity, 16x, steady feed in queue mode
    cfg_len = 2'd1; cfg_par_en = 1'b0; cfg_os8 = 1'b0; tick_div = 2;
    for (int i = 0; i < 5; i++) send(byte'(8'hC3 ^ i));
    drain();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 5);
    done = 1;
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule